// File: doc/BRIEF.md
# Transmit FIFO almost-empty interrupt unit

This block holds the bytes a host queues for transmission and hands them, one at a time, to a line-side consumer. The consumer drains the queue at its own pace. The block raises an interrupt when the queue runs low, so the host knows to refill it before it runs dry. The queue holds twelve bytes. It is low when it holds two bytes or fewer.

The interrupt has an enable bit that the host can see and clear. When the host clears it, the low-level interrupt is silenced. The enable sets itself again once the queue has been refilled to three bytes or more. An idle, empty queue therefore stays quiet after the host has acknowledged it. The interrupt fires again the next time a refilled queue drains below three bytes. If the consumer drains faster than the host refills, the interrupt stays high or returns. A write to a full queue is dropped and sets a sticky overflow bit.

Top module: `txe_irq_unit`

## Requirements
- R1: While reset is low at a clock edge, the unit returns to: level 0, enable bit 1, overflow 0. An empty queue therefore asserts the interrupt right after reset.
- R2: An accepted write adds one byte and raises the level by one. An accepted pop removes one byte and lowers the level by one. Bytes leave in the order they were written. `line_data` always shows the oldest byte while the level is above 0.
- R3: A write while the level is 12 is dropped. The level stays 12, the stored bytes are unchanged, and the overflow bit goes to 1. The overflow bit stays 1 until reset.
- R4: A pop while the level is 0 is ignored, and the level stays 0.
- R5: When a write and a pop arrive in the same cycle with a level between 1 and 11, both take effect and the level is unchanged. At level 0 only the write takes effect. At level 12 only the pop takes effect, and the dropped write sets overflow.
- R6: The interrupt is high exactly when the enable bit is 1 and the level is 2 or less. Both are evaluated on the state after the most recent clock edge.
- R7: A clear request clears the enable bit at the next edge, and the interrupt goes low with it.
- R8: While the enable bit is 0, it returns to 1 at the edge where the resulting level is 3 or more. Below that level it stays 0, whatever the traffic.
- R9: A clear request wins over a rearm at the same edge. If the level is still 3 or more at the following edge, the enable bit returns to 1 there.
- R10: With the enable bit at 1, a pop that takes the level from 3 to 2 raises the interrupt at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe for one byte |
| host_data | input | 8 | Byte written by the host |
| host_clr | input | 1 | Host request to clear the interrupt enable bit |
| line_pop | input | 1 | Consumer takes the oldest byte |
| line_data | output | 8 | Oldest byte in the queue |
| fill_level | output | 4 | Number of bytes held (0 to 12) |
| txe_stat | output | 1 | Interrupt enable bit (1 = armed) |
| txe_irq | output | 1 | Almost-empty interrupt |
| ovf_sticky | output | 1 | Sticky flag for a write dropped at full |

## Verification
Every result of this block is due at the first rising edge after its stimulus: the level, the oldest byte, the enable bit, the interrupt and the overflow bit. None of them has a further register stage, because the interrupt and the head byte are decoded directly from registered state. The bench changes inputs on the falling edge and samples all outputs on the next falling edge, half a cycle after the edge that acts on them. A bench model updated at that same edge supplies the expected values. Directed sequences place the level-2/level-3 crossings, a clear at a refilled level, and full/empty collisions on exact edges. Seeded random traffic around the threshold covers the remaining interleavings.

// File: rtl/txe_pkg.sv
// Package: shared types and helpers for the transmit almost-empty unit.
// Assumes: pointers index a storage array whose depth need not be a power of two.
package txe_pkg;

    // Accepted-transfer pair produced by the occupancy counter.
    typedef struct packed {
        logic push_ok;
        logic pop_ok;
    } txe_xfer_t;

    // Next value of a circular pointer over 0..depth-1.
    function automatic int wrap_next(input int ptr, input int depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/txe_level.sv
// Module: occupancy counter. Decides which requests are accepted, tracks the
// level and the sticky overflow bit, and exposes the level after this edge.
// Assumes: the level never exceeds DEPTH; synchronous active-low reset.
module txe_level
    import txe_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_req,
    input  logic             pop_req,
    output txe_xfer_t        xfer,
    output logic [CNT_W-1:0] level,
    output logic [CNT_W-1:0] level_nxt,
    output logic             ovf
);

    localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    logic full;
    logic empty;

    // Accept writes only with room, pops only with data.
    always_comb begin
        full         = (level == FULL_C);
        empty        = (level == '0);
        xfer.push_ok = wr_req && !full;
        xfer.pop_ok  = pop_req && !empty;
    end

    // Level resulting from this cycle's accepted transfers.
    always_comb begin
        unique case ({xfer.push_ok, xfer.pop_ok})
            2'b10:   level_nxt = level + ONE_C;
            2'b01:   level_nxt = level - ONE_C;
            default: level_nxt = level;
        endcase
    end

    // Register the level and latch overflow on a write dropped at full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            ovf   <= 1'b0;
        end else begin
            level <= level_nxt;
            if (wr_req && full) begin
                ovf <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/txe_store.sv
// Module: circular byte storage with a write and a read pointer.
// Assumes: push and pop are pre-qualified by the occupancy counter, so no
// overrun or underrun reaches this module. Entries are not reset.
module txe_store
    import txe_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 12,
    parameter int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;

    // Advance pointers on accepted transfers, wrapping at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) begin
                wr_ptr <= PTR_W'(wrap_next(int'(wr_ptr), DEPTH));
            end
            if (pop) begin
                rd_ptr <= PTR_W'(wrap_next(int'(rd_ptr), DEPTH));
            end
        end
    end

    // One write-enabled register per entry.
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (push && (wr_ptr == PTR_W'(i))) begin
                mem[i] <= din;
            end
        end
    end

    // Oldest entry is always visible.
    always_comb begin
        dout = mem[rd_ptr];
    end

endmodule

// File: rtl/txe_arm.sv
// Module: interrupt enable and decode. Clearing disarms; refilling to the
// rearm mark rearms; the interrupt is the enable AND the low-level condition.
// Assumes: level_nxt is the level that will be registered at this edge.
module txe_arm #(
    parameter int CNT_W      = 4,
    parameter int LOW_MARK   = 2,
    parameter int REARM_MARK = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] level,
    input  logic [CNT_W-1:0] level_nxt,
    output logic             armed,
    output logic             irq
);

    localparam logic [CNT_W-1:0] LOW_C   = CNT_W'(LOW_MARK);
    localparam logic [CNT_W-1:0] REARM_C = CNT_W'(REARM_MARK);

    // Enable bit: reset armed, clear wins, rearm on the refilled level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (clr) begin
            armed <= 1'b0;
        end else if (!armed && (level_nxt >= REARM_C)) begin
            armed <= 1'b1;
        end
    end

    // Interrupt decoded from registered state only.
    always_comb begin
        irq = armed && (level <= LOW_C);
    end

endmodule

// File: rtl/txe_irq_unit.sv
// Module: transmit FIFO with almost-empty interrupt (top).
// Host writes bytes and may clear the interrupt enable; the line side pops.
// Assumes: one byte per cycle each way; synchronous active-low reset.
module txe_irq_unit
    import txe_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int DEPTH      = 12,
    parameter int LOW_MARK   = 2,
    parameter int REARM_MARK = 3,
    localparam int CNT_W     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_clr,
    input  logic              line_pop,
    output logic [DATA_W-1:0] line_data,
    output logic [CNT_W-1:0]  fill_level,
    output logic              txe_stat,
    output logic              txe_irq,
    output logic              ovf_sticky
);

    txe_xfer_t        xfer;
    logic [CNT_W-1:0] level_nxt;

    txe_level #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W)
    ) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (host_wr),
        .pop_req   (line_pop),
        .xfer      (xfer),
        .level     (fill_level),
        .level_nxt (level_nxt),
        .ovf       (ovf_sticky)
    );

    txe_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (xfer.push_ok),
        .pop   (xfer.pop_ok),
        .din   (host_data),
        .dout  (line_data)
    );

    txe_arm #(
        .CNT_W      (CNT_W),
        .LOW_MARK   (LOW_MARK),
        .REARM_MARK (REARM_MARK)
    ) u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (host_clr),
        .level     (fill_level),
        .level_nxt (level_nxt),
        .armed     (txe_stat),
        .irq       (txe_irq)
    );

endmodule

// File: rtl/txe_irq_unit_chk.sv
// Module: protocol checker for txe_irq_unit, attached by bind below.
// Assumes: observes only the top-level ports.
module txe_irq_unit_chk #(
    parameter int DEPTH      = 12,
    parameter int LOW_MARK   = 2,
    parameter int REARM_MARK = 3,
    parameter int CNT_W      = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_clr,
    input logic             line_pop,
    input logic [CNT_W-1:0] fill_level,
    input logic             txe_stat,
    input logic             txe_irq,
    input logic             ovf_sticky
);

    localparam logic [CNT_W-1:0] FULL_C  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] REARM_C = CNT_W'(REARM_MARK);
    localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

    // R1: reset state
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (fill_level == '0) && txe_stat && !ovf_sticky);

    // R2: a lone accepted write raises the level by one
    a_r2_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !line_pop && (fill_level != FULL_C))
        |=> (fill_level == $past(fill_level) + ONE_C));

    // R3: write at full is dropped and flags overflow
    a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !line_pop && (fill_level == FULL_C))
        |=> (fill_level == FULL_C) && ovf_sticky);

    // R3: overflow is sticky
    a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky);

    // R4: pop on empty is ignored
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (line_pop && !host_wr && (fill_level == '0)) |=> (fill_level == '0));

    // R5: simultaneous transfer keeps the level
    a_r5_both_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && line_pop && (fill_level != '0) && (fill_level != FULL_C))
        |=> $stable(fill_level));

    // R6: no interrupt while disarmed
    a_r6_quiet_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
        !txe_stat |-> !txe_irq);

    // R7: clear disarms at the next edge
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        host_clr |=> !txe_stat && !txe_irq);

    // R8: refilled level with no pop rearms
    a_r8_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (!txe_stat && !host_clr && !line_pop && (fill_level >= REARM_C))
        |=> txe_stat);

endmodule

bind txe_irq_unit txe_irq_unit_chk #(
    .DEPTH      (DEPTH),
    .LOW_MARK   (LOW_MARK),
    .REARM_MARK (REARM_MARK),
    .CNT_W      (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_clr   (host_clr),
    .line_pop   (line_pop),
    .fill_level (fill_level),
    .txe_stat   (txe_stat),
    .txe_irq    (txe_irq),
    .ovf_sticky (ovf_sticky)
);

// File: tb/txe_irq_unit_tb.sv
// Bench: directed corners plus seeded random traffic, checked against a
// model built from the requirements. Inputs change on the falling edge;
// outputs are sampled on the falling edge after the acting rising edge.
module txe_irq_unit_tb;

    localparam int DEPTH = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = '0;
    logic       host_clr = 1'b0;
    logic       line_pop = 1'b0;
    logic [7:0] line_data;
    logic [3:0] fill_level;
    logic       txe_stat;
    logic       txe_irq;
    logic       ovf_sticky;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Model state.
    logic [7:0] q[$];
    bit         m_armed;
    bit         m_ovf;

    always #5 clk = ~clk;

    txe_irq_unit u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_data  (host_data),
        .host_clr   (host_clr),
        .line_pop   (line_pop),
        .line_data  (line_data),
        .fill_level (fill_level),
        .txe_stat   (txe_stat),
        .txe_irq    (txe_irq),
        .ovf_sticky (ovf_sticky)
    );

    function automatic bit exp_irq(input bit armed, input int lvl);
        return armed && (lvl <= 2);
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare every output against the model.
    task automatic check_all();
        check("R2 level", int'(fill_level), q.size());
        if (q.size() > 0) check("R2 head byte", int'(line_data), int'(q[0]));
        check("R7 enable", int'(txe_stat), int'(m_armed));
        check("R6 irq", int'(txe_irq), int'(exp_irq(m_armed, q.size())));
        check("R3 overflow", int'(ovf_sticky), int'(m_ovf));
    endtask

    // One cycle: drive, advance the model at the rising edge, sample later.
    task automatic step(input bit wr, input logic [7:0] d, input bit pop, input bit clr);
        bit push_ok;
        bit pop_ok;
        host_wr   = wr;
        host_data = d;
        line_pop  = pop;
        host_clr  = clr;
        @(posedge clk);
        push_ok = wr && (q.size() < DEPTH);
        pop_ok  = pop && (q.size() > 0);
        if (wr && (q.size() == DEPTH)) m_ovf = 1'b1;
        if (pop_ok) void'(q.pop_front());
        if (push_ok) q.push_back(d);
        if (clr) m_armed = 1'b0;
        else if (!m_armed && (q.size() >= 3)) m_armed = 1'b1;
        @(negedge clk);
        host_wr  = 1'b0;
        line_pop = 1'b0;
        host_clr = 1'b0;
        check_all();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // Reset applied at the last rising edge while rst_n was low.
        rst_n   = 1'b1;
        m_armed = 1'b1;
        m_ovf   = 1'b0;
        check("R1 level", int'(fill_level), 0);
        check("R1 enable", int'(txe_stat), 1);
        check("R1 irq on empty", int'(txe_irq), 1);
        check("R1 overflow", int'(ovf_sticky), 0);

        // R7: clear disarms; the empty idle queue stays quiet.
        step(0, 8'h00, 0, 1);
        check("R7 cleared irq", int'(txe_irq), 0);
        step(0, 8'h00, 0, 0);
        check("R7 idle quiet", int'(txe_irq), 0);

        // R8: two bytes do not rearm, the third does.
        step(1, 8'hA1, 0, 0);
        step(1, 8'hA2, 0, 0);
        check("R8 not yet armed", int'(txe_stat), 0);
        step(1, 8'hA3, 0, 0);
        check("R8 rearm at 3", int'(txe_stat), 1);
        check("R8 irq low at 3", int'(txe_irq), 0);

        // R10: a pop from 3 to 2 fires the interrupt.
        step(0, 8'h00, 1, 0);
        check("R10 irq at 2", int'(txe_irq), 1);
        check("R2 fifo order", int'(line_data), 8'hA2);
        step(1, 8'hA4, 0, 0);
        check("R6 irq off at 3", int'(txe_irq), 0);

        // R3: fill to full, then write once more.
        for (int i = 0; i < 9; i++) step(1, 8'(8'hB0 + i), 0, 0);
        check("R3 full level", int'(fill_level), DEPTH);
        step(1, 8'hEE, 0, 0);
        check("R3 drop level", int'(fill_level), DEPTH);
        check("R3 overflow set", int'(ovf_sticky), 1);
        // R5: at full, a write with a pop lets only the pop through.
        step(1, 8'hEF, 1, 0);
        check("R5 full both", int'(fill_level), DEPTH - 1);

        // R2: drain and check order on every step, then R4 on empty.
        while (q.size() > 0) step(0, 8'h00, 1, 0);
        step(0, 8'h00, 1, 0);
        check("R4 empty pop", int'(fill_level), 0);
        check("R3 overflow sticky", int'(ovf_sticky), 1);

        // R5: at empty, write with pop accepts only the write.
        step(1, 8'hC0, 1, 0);
        check("R5 empty both", int'(fill_level), 1);
        for (int i = 0; i < 4; i++) step(1, 8'(8'hC1 + i), 0, 0);
        step(1, 8'hD0, 1, 0);
        check("R5 mid both", int'(fill_level), 5);

        // R9: clear at level 5 disarms, rearm follows one edge later.
        step(0, 8'h00, 0, 1);
        check("R9 clear wins", int'(txe_stat), 0);
        step(0, 8'h00, 0, 0);
        check("R9 rearm next edge", int'(txe_stat), 1);

        // Random traffic around the threshold.
        for (int n = 0; n < 6000; n++) begin
            int wp;
            wp = ((n / 500) % 2 == 0) ? 55 : 40;
            step(($urandom % 100) < wp, 8'($urandom), ($urandom % 100) < 50,
                 ($urandom % 100) < 4);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule